// File: doc/BRIEF.md
# Host Memory Window Access Checker

This block lets a host reach local SRAM through two independently programmed windows. Each window holds a base address, a pair of limits (one for reads, one for writes) and an index register. The host places an offset into a window's index register and then issues 8-, 16- or 32-bit data reads and writes. Each data access is checked against that window's limits. An access that passes becomes one word-wide SRAM request with byte enables, and the index then moves forward by the access size. An access that fails never reaches the SRAM. A blocked read answers zero and a blocked write vanishes. In both cases the index keeps its value.

Host commands arrive on a valid/ready stream. The block takes one command at a time: `cmd_ready` is high only while nothing is in flight. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. The SRAM request port is also valid/ready. The SRAM may hold `sram_req_ready` low for as long as it likes, and the request fields stay frozen until it accepts. Read data comes back on `sram_rvalid` after the request is accepted. Read results go to the host on a valid/ready response stream, and `rsp_data` stays constant until `rsp_ready` takes it. Writes produce no response.

Because the two limits are independent, a window can take several forms. With both limits zero it is disabled. It can be read-only or write-only. It can also be split, with a read/write low part and an upper part that is read-only or write-only.

Top module: `emwin_access_top`

## Requirements
- R1: After reset, `cmd_ready` is 1 and both `sram_req_valid` and `rsp_valid` are 0. Every window has base 0, limits 0 (disabled) and index 0, so any data read returns 0 and any data write issues no SRAM request.
- R2: Operation code 0 writes `cmd_wdata` to the selected window's base register, and bits [1:0] of the base are ignored. A permitted access targets SRAM word address (base[31:2] + index[14:2]) modulo 2^SRAM_AW.
- R3: Operation code 1 writes the limits register. The read limit is bits [15:0] and the write limit is bits [31:16]. Both are byte offsets from the base, compared at word granularity (bits [15:2]). Operation code 2 writes the index from `cmd_wdata[14:0]`.
- R4: A read (code 3) is permitted only when index[14:2] is below read_limit[15:2]. A blocked read returns `rsp_data` 0, issues no SRAM request and leaves the index unchanged.
- R5: A write (code 4) is permitted only when index[14:2] is below write_limit[15:2]. A blocked write is dropped with no SRAM request, and the index is unchanged.
- R6: Mixed limits give split windows. When write limit < read limit, offsets below the write limit are read/write and offsets between the two limits are read-only. When read limit < write limit, the upper part is write-only.
- R7: `cmd_size` sets the width: 0 is a byte, 1 is a halfword, and 2 or 3 is a word. A byte uses lane index[1:0]. A halfword uses lanes {index[1],0} and {index[1],1}. A word uses all four lanes. Write data is taken right-aligned from `cmd_wdata`. Read data is returned right-aligned and zero-extended.
- R8: After each permitted access, the index advances by 1, 2 or 4 bytes according to the size, wrapping modulo 2^15.
- R9: One command is in flight at a time. `cmd_ready` stays low from a permitted access, or a blocked read, until that command completes. Codes 5 to 7 are accepted and have no effect.
- R10: While `sram_req_valid` is high and `sram_req_ready` is low, the request fields and the valid stay stable.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and the valid stay stable.
- R12: The windows are independent. Commands to one window never change another window's base, limits or index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Block ready for a command |
| cmd_op | input | 3 | Operation code (see R2 to R5, R9) |
| cmd_win | input | $clog2(NUM_WIN) | Window select |
| cmd_size | input | 2 | Data access size (see R7) |
| cmd_wdata | input | 32 | Register value or right-aligned write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_data | output | 32 | Right-aligned read result |
| sram_req_valid | output | 1 | SRAM request valid |
| sram_req_ready | input | 1 | SRAM accepts the request |
| sram_req_we | output | 1 | 1 for write, 0 for read |
| sram_req_addr | output | SRAM_AW | SRAM word address |
| sram_req_be | output | 4 | Byte enables |
| sram_req_wdata | output | 32 | Lane-aligned write data |
| sram_rvalid | input | 1 | SRAM read data valid |
| sram_rdata | input | 32 | SRAM read word |

## Verification
The hardest situations to reach from the ports are the ones where an access sits exactly at a limit edge and its outcome can only be seen indirectly. One example is whether a blocked read left the index alone. Another is whether a halfword write at offset 0x7FFE wrapped the index to zero. The stimulus programs write-only, read-only and split windows and steps the index across each word boundary. It then reprograms the limits and reads back through the same index to expose any advance that should not have happened. Throughout the run, the SRAM accept and host response readies are driven from a pseudo-random sequence, so both hold rules are exercised under stalls.

// File: rtl/emwin_pkg.sv
package emwin_pkg;

  typedef enum logic [2:0] {
    OP_SET_BASE  = 3'd0,
    OP_SET_LIMIT = 3'd1,
    OP_SET_INDEX = 3'd2,
    OP_READ      = 3'd3,
    OP_WRITE     = 3'd4
  } emwin_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_RSP
  } emwin_st_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/emwin_lanes.sv
module emwin_lanes (
  input  logic [1:0]  size,
  input  logic [1:0]  off,
  input  logic [31:0] wdata,
  output logic [1:0]  shift,
  output logic [3:0]  be,
  output logic [31:0] wdata_al,
  output logic [31:0] rmask
);
  always_comb begin
    case (size)
      2'd0: begin
        shift = off;
        be    = 4'b0001 << off;
        rmask = 32'h0000_00FF;
      end
      2'd1: begin
        shift = {off[1], 1'b0};
        be    = 4'b0011 << {off[1], 1'b0};
        rmask = 32'h0000_FFFF;
      end
      default: begin
        shift = 2'd0;
        be    = 4'b1111;
        rmask = 32'hFFFF_FFFF;
      end
    endcase
    wdata_al = wdata << {shift, 3'b000};
  end
endmodule

// File: rtl/emwin_window.sv
module emwin_window #(
  parameter int IDX_W   = 15,
  parameter int SRAM_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_base,
  input  logic               wr_limit,
  input  logic               wr_index,
  input  logic [31:0]        wdata,
  input  logic               adv,
  input  logic [2:0]         adv_bytes,
  output logic [1:0]         off,
  output logic               rd_ok,
  output logic               wr_ok,
  output logic [SRAM_AW-1:0] word_addr
);
  localparam int BASE_W = 30;

  logic [BASE_W-1:0] base_q;
  logic [31:0]       lim_q;
  logic [IDX_W-1:0]  index_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      lim_q   <= '0;
      index_q <= '0;
    end else begin
      if (wr_base)  base_q <= wdata[31:2];
      if (wr_limit) lim_q  <= wdata;
      if (wr_index)  index_q <= wdata[IDX_W-1:0];
      else if (adv)  index_q <= index_q + IDX_W'(adv_bytes);
    end
  end

  assign off       = index_q[1:0];
  assign rd_ok     = 16'(index_q[IDX_W-1:2]) < 16'(lim_q[15:2]);
  assign wr_ok     = 16'(index_q[IDX_W-1:2]) < 16'(lim_q[31:18]);
  assign word_addr = SRAM_AW'(base_q + BASE_W'(index_q[IDX_W-1:2]));

  // R8: the index only advances on an access that this window permits
  assert_adv_permitted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (rd_ok || wr_ok));

  // R5 / R12: without an index write or an advance, the index holds
  assert_index_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_index && !adv) |=> $stable(index_q));
endmodule

// File: rtl/emwin_access_top.sv
module emwin_access_top
  import emwin_pkg::*;
#(
  parameter int NUM_WIN = 2,
  parameter int IDX_W   = 15,
  parameter int SRAM_AW = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [2:0]                 cmd_op,
  input  logic [$clog2(NUM_WIN)-1:0] cmd_win,
  input  logic [1:0]                 cmd_size,
  input  logic [31:0]                cmd_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [31:0]                rsp_data,
  output logic                       sram_req_valid,
  input  logic                       sram_req_ready,
  output logic                       sram_req_we,
  output logic [SRAM_AW-1:0]         sram_req_addr,
  output logic [3:0]                 sram_req_be,
  output logic [31:0]                sram_req_wdata,
  input  logic                       sram_rvalid,
  input  logic [31:0]                sram_rdata
);
  localparam int WIN_W = $clog2(NUM_WIN);

  emwin_st_e st_q;
  logic accept, is_rd, is_wr, permit;
  logic [2:0] step_bytes;

  logic [1:0]         off_w   [NUM_WIN];
  logic               rd_ok_w [NUM_WIN];
  logic               wr_ok_w [NUM_WIN];
  logic [SRAM_AW-1:0] addr_w  [NUM_WIN];

  logic sel_rd_ok, sel_wr_ok;
  logic [1:0] sel_off;
  logic [SRAM_AW-1:0] sel_addr;

  assign cmd_ready  = (st_q == ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign is_rd      = (cmd_op == OP_READ);
  assign is_wr      = (cmd_op == OP_WRITE);
  assign step_bytes = size_bytes(cmd_size);

  assign sel_rd_ok = rd_ok_w[cmd_win];
  assign sel_wr_ok = wr_ok_w[cmd_win];
  assign sel_off   = off_w[cmd_win];
  assign sel_addr  = addr_w[cmd_win];
  assign permit    = (is_rd && sel_rd_ok) || (is_wr && sel_wr_ok);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic hit;
    assign hit = accept && (cmd_win == WIN_W'(g));
    emwin_window #(.IDX_W(IDX_W), .SRAM_AW(SRAM_AW)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_base   (hit && (cmd_op == OP_SET_BASE)),
      .wr_limit  (hit && (cmd_op == OP_SET_LIMIT)),
      .wr_index  (hit && (cmd_op == OP_SET_INDEX)),
      .wdata     (cmd_wdata),
      .adv       (hit && permit),
      .adv_bytes (step_bytes),
      .off       (off_w[g]),
      .rd_ok     (rd_ok_w[g]),
      .wr_ok     (wr_ok_w[g]),
      .word_addr (addr_w[g])
    );
  end

  logic [1:0]  ln_shift;
  logic [3:0]  ln_be;
  logic [31:0] ln_wdata, ln_mask;

  emwin_lanes u_lanes (
    .size     (cmd_size),
    .off      (sel_off),
    .wdata    (cmd_wdata),
    .shift    (ln_shift),
    .be       (ln_be),
    .wdata_al (ln_wdata),
    .rmask    (ln_mask)
  );

  logic [1:0]  shift_q;
  logic [31:0] mask_q, rsp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q           <= ST_IDLE;
      sram_req_we    <= 1'b0;
      sram_req_addr  <= '0;
      sram_req_be    <= '0;
      sram_req_wdata <= '0;
      shift_q        <= '0;
      mask_q         <= '0;
      rsp_q          <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          if (permit) begin
            sram_req_we    <= is_wr;
            sram_req_addr  <= sel_addr;
            sram_req_be    <= ln_be;
            sram_req_wdata <= ln_wdata;
            shift_q        <= ln_shift;
            mask_q         <= ln_mask;
            st_q           <= ST_REQ;
          end else if (is_rd) begin
            rsp_q <= '0;
            st_q  <= ST_RSP;
          end
        end
        ST_REQ: if (sram_req_ready) st_q <= sram_req_we ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (sram_rvalid) begin
          rsp_q <= (sram_rdata >> {shift_q, 3'b000}) & mask_q;
          st_q  <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sram_req_valid = (st_q == ST_REQ);
  assign rsp_valid      = (st_q == ST_RSP);
  assign rsp_data       = rsp_q;

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_req_valid && !sram_req_ready) |=> (sram_req_valid && $stable(sram_req_addr)
      && $stable(sram_req_be) && $stable(sram_req_wdata) && $stable(sram_req_we)));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_read_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_rd && sel_rd_ok) |=> (sram_req_valid && !sram_req_we));

  assert_read_blocked_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_rd && !sel_rd_ok) |=> (rsp_valid && rsp_data == 32'd0 && !sram_req_valid));

  assert_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_wr && !sel_wr_ok) |=> (cmd_ready && !sram_req_valid));

  assert_be_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_req_valid |-> ($countones(sram_req_be) == 1 || $countones(sram_req_be) == 2
      || $countones(sram_req_be) == 4));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_req_valid || rsp_valid) |-> !cmd_ready);
endmodule

// File: tb/sim_emwin_access_top.sv
module sim_emwin_access_top;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [0:0]  cmd_win = '0;
  logic [1:0]  cmd_size = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_data;
  logic        sram_req_valid, sram_req_ready, sram_req_we;
  logic [AW-1:0] sram_req_addr;
  logic [3:0]  sram_req_be;
  logic [31:0] sram_req_wdata;
  logic        sram_rvalid;
  logic [31:0] sram_rdata;

  emwin_access_top #(.NUM_WIN(2), .IDX_W(15), .SRAM_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_win(cmd_win), .cmd_size(cmd_size), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sram_req_valid(sram_req_valid), .sram_req_ready(sram_req_ready),
    .sram_req_we(sram_req_we), .sram_req_addr(sram_req_addr), .sram_req_be(sram_req_be),
    .sram_req_wdata(sram_req_wdata), .sram_rvalid(sram_rvalid), .sram_rdata(sram_rdata)
  );

  int checks = 0;
  int failures = 0;
  int req_seen = 0;
  int exp_req = 0;
  int req_stalls = 0;
  int rsp_stalls = 0;
  bit finished = 1'b0;

  logic [31:0] mem [DEPTH];
  logic [31:0] ref_mem [DEPTH];
  logic [31:0] m_base [2];
  logic [31:0] m_lim [2];
  logic [14:0] m_idx [2];

  logic [31:0] exp_rsp_q [$];
  string       exp_tag_q [$];
  logic [14:0] exp_req_q [$];

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // pseudo-random back-pressure on both handshakes
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    lfsr           <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sram_req_ready <= lfsr[0] | lfsr[3];
    rsp_ready      <= lfsr[5] | lfsr[8];
  end

  // behavioural SRAM with a request scoreboard
  always @(posedge clk) begin
    sram_rvalid <= 1'b0;
    if (rst_n && sram_req_valid && !sram_req_ready) req_stalls++;
    if (rst_n && sram_req_valid && sram_req_ready) begin
      req_seen++;
      if (exp_req_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R5 unexpected SRAM request actual=%h expected=none",
                 {sram_req_we, sram_req_addr, sram_req_be});
      end else begin
        check_eq("R2/R7 request we/addr/be", 32'({sram_req_we, sram_req_addr, sram_req_be}),
                 32'(exp_req_q.pop_front()));
      end
      if (sram_req_we) begin
        for (int b = 0; b < 4; b++)
          if (sram_req_be[b]) mem[sram_req_addr][8*b +: 8] <= sram_req_wdata[8*b +: 8];
      end else begin
        sram_rdata  <= mem[sram_req_addr];
        sram_rvalid <= 1'b1;
      end
    end
  end

  // response monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !rsp_ready) rsp_stalls++;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_rsp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R4 unexpected response actual=%h expected=none", rsp_data);
      end else begin
        check_eq(exp_tag_q.pop_front(), rsp_data, exp_rsp_q.pop_front());
      end
    end
  end

  task automatic do_cmd(input logic [2:0] op, input int w, input logic [1:0] sz,
                        input logic [31:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_win = w[0]; cmd_size = sz; cmd_wdata = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic set_base(input int w, input logic [31:0] v);
    m_base[w] = v; do_cmd(3'd0, w, 2'd0, v);
  endtask
  task automatic set_limit(input int w, input logic [31:0] v);
    m_lim[w] = v; do_cmd(3'd1, w, 2'd0, v);
  endtask
  task automatic set_index(input int w, input logic [14:0] v);
    m_idx[w] = v; do_cmd(3'd2, w, 2'd0, 32'(v));
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction
  function automatic int lane_of(input logic [14:0] idx, input logic [1:0] sz);
    if (sz == 2'd0) return int'(idx[1:0]);
    if (sz == 2'd1) return idx[1] ? 2 : 0;
    return 0;
  endfunction
  function automatic logic [AW-1:0] waddr(input int w);
    return AW'((m_base[w] >> 2) + 32'(m_idx[w] >> 2));
  endfunction
  function automatic logic [3:0] be_of(input int lane, input int n);
    logic [3:0] r = '0;
    for (int b = 0; b < n; b++) r[lane + b] = 1'b1;
    return r;
  endfunction

  task automatic h_read(input int w, input logic [1:0] sz, input string tag);
    logic [31:0] v = '0;
    int lane = lane_of(m_idx[w], sz);
    int n = nbytes(sz);
    if (32'(m_idx[w] >> 2) < 32'(m_lim[w][15:2])) begin
      for (int b = 0; b < n; b++) v[8*b +: 8] = ref_mem[waddr(w)][8*(lane + b) +: 8];
      exp_req_q.push_back({1'b0, waddr(w), be_of(lane, n)});
      exp_req++;
      m_idx[w] = m_idx[w] + 15'(n);
    end
    exp_rsp_q.push_back(v);
    exp_tag_q.push_back(tag);
    do_cmd(3'd3, w, sz, 32'hFFFF_FFFF);
  endtask

  task automatic h_write(input int w, input logic [1:0] sz, input logic [31:0] d);
    int lane = lane_of(m_idx[w], sz);
    int n = nbytes(sz);
    if (32'(m_idx[w] >> 2) < 32'(m_lim[w][31:18])) begin
      for (int b = 0; b < n; b++) ref_mem[waddr(w)][8*(lane + b) +: 8] = d[8*b +: 8];
      exp_req_q.push_back({1'b1, waddr(w), be_of(lane, n)});
      exp_req++;
      m_idx[w] = m_idx[w] + 15'(n);
    end
    do_cmd(3'd4, w, sz, d);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]     = (32'(i) * 32'h0001_0003) ^ 32'h5A5A_C3C3;
      ref_mem[i] = (32'(i) * 32'h0001_0003) ^ 32'h5A5A_C3C3;
    end
    for (int w = 0; w < 2; w++) begin m_base[w] = '0; m_lim[w] = '0; m_idx[w] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and disabled windows
    check_eq("R1 cmd_ready after reset", 32'(cmd_ready), 32'd1);
    check_eq("R1 sram_req_valid after reset", 32'(sram_req_valid), 32'd0);
    check_eq("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    h_read(0, 2'd2, "R1 read of disabled window 0");
    h_read(1, 2'd2, "R1 read of disabled window 1");
    h_write(0, 2'd2, 32'h1111_1111);
    wait_idle();
    check_eq("R1 no SRAM request while disabled", 32'(req_seen), 32'(exp_req));

    // R2/R3: base low bits ignored, address mapping, limit fields
    set_base(0, 32'h0000_0103);
    set_limit(0, 32'h0040_0040);
    set_index(0, 15'h0);
    h_write(0, 2'd2, 32'hDEAD_BEEF);
    set_index(0, 15'h0);
    h_read(0, 2'd2, "R2 word readback");
    h_read(0, 2'd2, "R3 read at next word");

    // R7: sizes and lanes
    set_index(0, 15'h4);
    h_write(0, 2'd0, 32'h0000_0011);
    h_write(0, 2'd0, 32'h0000_0022);
    h_write(0, 2'd0, 32'h0000_0033);
    h_write(0, 2'd0, 32'h0000_0044);
    set_index(0, 15'h4);
    h_read(0, 2'd2, "R7 word from four byte writes");
    set_index(0, 15'h5);
    h_read(0, 2'd0, "R7 byte lane 1");
    h_read(0, 2'd1, "R7 half lanes 2-3");
    set_index(0, 15'h8);
    h_write(0, 2'd1, 32'hFFFF_BEEF);
    h_write(0, 2'd3, 32'h0000_CAFE);
    set_index(0, 15'h9);
    h_read(0, 2'd1, "R7 half at odd offset uses lane 0");
    set_index(0, 15'h8);
    h_read(0, 2'd2, "R7 word after half writes");

    // R4/R5: boundary at the limit word
    set_index(0, 15'h3C);
    h_write(0, 2'd2, 32'hA5A5_0F0F);
    h_read(0, 2'd2, "R4 read at limit blocked");
    h_write(0, 2'd2, 32'h7777_7777);
    set_index(0, 15'h3C);
    h_read(0, 2'd2, "R4 read below limit");
    wait_idle();
    check_eq("R5 blocked write issues no request", 32'(req_seen), 32'(exp_req));

    // R6: split windows
    set_base(1, 32'h0000_0800);
    set_limit(1, 32'h0010_0020);
    set_index(1, 15'h0C);
    h_write(1, 2'd2, 32'h0C0C_0C0C);
    h_write(1, 2'd2, 32'h1010_1010);
    set_index(1, 15'h18);
    h_read(1, 2'd2, "R6 read-only upper part readable");
    set_index(1, 15'h10);
    h_read(1, 2'd2, "R6 upper write was dropped");
    set_limit(1, 32'h0020_0010);
    set_index(1, 15'h14);
    h_read(1, 2'd2, "R6 write-only upper part reads zero");
    h_write(1, 2'd2, 32'h1414_1414);
    set_limit(1, 32'h0020_0020);
    set_index(1, 15'h14);
    h_read(1, 2'd2, "R6 index held after blocked read");

    // R5: read-only and disabled
    set_limit(1, 32'h0000_0040);
    set_index(1, 15'h0);
    h_write(1, 2'd2, 32'hBAD0_BAD0);
    h_read(1, 2'd2, "R5 read-only window write dropped");
    set_limit(1, 32'h0);
    h_read(1, 2'd2, "R5 disabled window reads zero");
    wait_idle();
    check_eq("R5 request count", 32'(req_seen), 32'(exp_req));

    // R12: interleaved windows
    set_limit(1, 32'h0040_0040);
    set_index(0, 15'h0);
    set_index(1, 15'h0C);
    h_read(0, 2'd2, "R12 window 0 first");
    h_read(1, 2'd2, "R12 window 1 first");
    h_read(0, 2'd2, "R12 window 0 second");
    h_read(1, 2'd2, "R12 window 1 second");

    // R9: unknown op ignored, busy while in flight
    do_cmd(3'd7, 0, 2'd2, 32'hFFFF_FFFF);
    h_read(0, 2'd2, "R9 unknown op left window 0 intact");
    check_eq("R9 cmd_ready low during access", 32'(cmd_ready), 32'd0);

    // R8: wrap of the index
    set_limit(0, 32'hFFFC_FFFC);
    set_index(0, 15'h7FFE);
    h_write(0, 2'd1, 32'h0000_1234);
    h_write(0, 2'd2, 32'h0BAD_F00D);
    set_index(0, 15'h7FFC);
    h_read(0, 2'd2, "R8 word at top of index space");
    h_read(0, 2'd2, "R8 index wrapped to zero");

    wait_idle();
    repeat (4) @(negedge clk);
    check_eq("R10 request stalls seen", 32'(req_stalls > 0), 32'd1);
    check_eq("R11 response stalls seen", 32'(rsp_stalls > 0), 32'd1);
    check_eq("R4 all responses returned", 32'(exp_rsp_q.size()), 32'd0);
    check_eq("R5 all requests seen", 32'(req_seen), 32'(exp_req));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule